// File: doc/BRIEF.md
# Reference Clock Rate Detector

This block works out, without any configuration input, which of three supported reference frequencies is driving its reference input: 19.44 MHz, 77.76 MHz or 155.52 MHz. It measures the reference against the local timebase and reports a 2-bit rate code. It also gives the integer ratio that the oscillator must run at relative to that reference. A confirmation flag tells the consumer when the code is backed by the most recent measurements. A separate flag tells it when the reference has stopped, which the downstream lock logic uses to force its loss-of-lock alarm.

Inside the reference domain, the reference is prescaled by four and counted by a Gray-coded counter. That counter is brought across to the local clock through a two-stage synchronizer. The local domain takes the difference between snapshots at the end of every fixed window of `WIN_CYCLES` local cycles. It sorts the count into one of five categories: one of the three rates, too slow (absent), or between or beyond the ranges (unrecognised). A decision stage then applies two-window agreement rules before it changes the outputs.

Top module: `refrate_detect`

## Requirements
- R1: While reset is applied and on the first cycle after it, rate_code is 0, rate_valid is 0, ref_missing is 0 and vco_ratio is 128.
- R2: A window count, in units of four reference cycles over 2048 local cycles, is sorted into one of these categories. 94..106 is the low rate (code 0). 374..422 is the mid rate (code 1). 747..845 is the high rate (code 2).
- R3: rate_code takes a new value and rate_valid goes high only when two consecutive windows fall in the same rate range. A window in a different range drops rate_valid and keeps the code.
- R4: A count of 94 or more that lies outside all three ranges drives rate_valid low and leaves rate_code unchanged.
- R5: A count below 94 in two consecutive windows raises ref_missing. A single such window only drops rate_valid.
- R6: ref_missing falls after the first window whose count is 94 or more.
- R7: vco_ratio is 128, 32 or 16 when rate_code is 0, 1 or 2.
- R8: The first window after reset is discarded. Outputs change only on the cycle that follows the end of a window, and the first possible change follows the end of the second window.
- R9: rate_code never takes the value 3, and rate_valid is never high while ref_missing is high.
- R10: A reference 3 % above a nominal frequency is still classified as that rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock under measurement |
| rate_code | output | 2 | Detected rate: 0 low, 1 mid, 2 high |
| rate_valid | output | 1 | Rate code confirmed by the last two windows |
| ref_missing | output | 1 | Reference judged absent |
| vco_ratio | output | RATIO_W | Oscillator to reference multiplier for the current code |

## Verification
A window that starts at local edge k·2048 ends at edge (k+1)·2048. Its result appears on the outputs after edge (k+1)·2048+1: one register for the count snapshot and one for the decision. The bench counts edges from the release of reset and changes the reference half a cycle before a window boundary. Each window is therefore measured on one frequency, give or take a few synchronizer cycles that fall well inside the classification margins. A behavioural model queues the category of every window and applies it on that same edge. The outputs are compared with the model at every falling edge, and named checks confirm the expected values one half-cycle after each decision edge.

// File: rtl/refrate_pkg.sv
// Shared types for the reference rate detector.
package refrate_pkg;

    // Rate code presented on the top-level port
    typedef enum logic [1:0] {
        RATE_LOW  = 2'd0,
        RATE_MID  = 2'd1,
        RATE_HIGH = 2'd2
    } rate_e;

    // Category of one measurement window; the rate categories share
    // their low bits with rate_e so the decision stage can narrow them.
    typedef enum logic [2:0] {
        CAT_LOW    = 3'd0,
        CAT_MID    = 3'd1,
        CAT_HIGH   = 3'd2,
        CAT_ABSENT = 3'd3,
        CAT_OUT    = 3'd4
    } cat_e;

    localparam int NUM_RATES = 3;

endpackage

// File: rtl/refrate_ref_counter.sv
// Reference-domain edge counter.
// Divides the reference by 2**PRE_W and counts the divided ticks in a
// registered Gray code, so that at most one bit moves per tick.
// Assumes: PRE_W >= 1 and the divided rate is below the local clock rate;
// rst_n is re-timed into the reference domain here.
module refrate_ref_counter #(
    parameter int PRE_W = 2,
    parameter int CNT_W = 12
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_q
);

    logic [1:0]       rst_sync;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    // Re-time reset into the reference domain
    always_ff @(posedge ref_clk) begin
        rst_sync <= {rst_sync[0], rst_n};
    end

    // Prescale, count and re-encode in Gray
    always_ff @(posedge ref_clk) begin
        if (!rst_sync[1]) begin
            pre_q  <= '0;
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            if (&pre_q) begin
                bin_q  <= bin_nxt;
                gray_q <= bin_nxt ^ (bin_nxt >> 1);
            end
        end
    end

endmodule

// File: rtl/refrate_sync.sv
// Brings the Gray count into the local domain and converts it to binary.
// Assumes: the input changes in at most one bit between local samples.
module refrate_sync #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);

    logic [CNT_W-1:0] stage1;
    logic [CNT_W-1:0] stage2;

    // Two-flop synchronizer on every Gray bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of itself and all bits above
    for (genvar i = 0; i < CNT_W; i++) begin : g_g2b
        assign bin_out[i] = ^stage2[CNT_W-1:i];
    end

endmodule

// File: rtl/refrate_window.sv
// Fixed measurement window on the local clock.
// Every WIN_CYCLES cycles it snapshots the binary reference count and
// presents the difference from the previous snapshot with a one-cycle
// valid pulse. The first window after reset only primes the snapshot.
// Assumes: fewer than 2**CNT_W divided ticks occur in one window.
module refrate_window #(
    parameter int WIN_CYCLES = 2048,
    parameter int CNT_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] bin_now,
    output logic [CNT_W-1:0] count_q,
    output logic             count_vld
);

    localparam int             WIN_W = $clog2(WIN_CYCLES);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

    logic [WIN_W-1:0] wcnt;
    logic [CNT_W-1:0] prev_bin;
    logic             primed;
    logic             tick;

    assign tick = (wcnt == LAST);

    // Free-running window timer
    always_ff @(posedge clk) begin
        if (!rst_n)    wcnt <= '0;
        else if (tick) wcnt <= '0;
        else           wcnt <= wcnt + 1'b1;
    end

    // Snapshot and difference at each window end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bin  <= '0;
            count_q   <= '0;
            count_vld <= 1'b0;
            primed    <= 1'b0;
        end else begin
            count_vld <= tick & primed;
            if (tick) begin
                count_q  <= bin_now - prev_bin;
                prev_bin <= bin_now;
                primed   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/refrate_classify.sv
// Sorts one window count into a category.
// Each rate has a range of nominal +/- nominal/2**TOL_SHIFT; a count below
// the low rate's range counts as an absent reference.
// Assumes: NOM_LOW < NOM_MID < NOM_HIGH and the ranges do not overlap.
module refrate_classify
    import refrate_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int NOM_LOW   = 100,
    parameter int NOM_MID   = 398,
    parameter int NOM_HIGH  = 796,
    parameter int TOL_SHIFT = 4
) (
    input  logic [CNT_W-1:0] count,
    output cat_e             cat
);

    localparam int NOM [NUM_RATES] = '{NOM_LOW, NOM_MID, NOM_HIGH};
    localparam int LO_MIN = NOM_LOW - (NOM_LOW >> TOL_SHIFT);

    logic [NUM_RATES-1:0] hit;
    logic                 below_min;
    int                   count_i;

    assign count_i   = int'(count);
    assign below_min = (count_i < LO_MIN);

    // One range comparator per supported rate
    for (genvar k = 0; k < NUM_RATES; k++) begin : g_range
        localparam int LO = NOM[k] - (NOM[k] >> TOL_SHIFT);
        localparam int HI = NOM[k] + (NOM[k] >> TOL_SHIFT);
        assign hit[k] = (count_i >= LO) && (count_i <= HI);
    end

    // Priority: absent first, then the ranges, otherwise unrecognised
    always_comb begin
        if (below_min)   cat = CAT_ABSENT;
        else if (hit[0]) cat = CAT_LOW;
        else if (hit[1]) cat = CAT_MID;
        else if (hit[2]) cat = CAT_HIGH;
        else             cat = CAT_OUT;
    end

endmodule

// File: rtl/refrate_decide.sv
// Agreement rules over consecutive windows.
// A rate is confirmed when two windows in a row share it; two absent
// windows in a row flag a missing reference; anything else drops the
// confirmation but keeps the last confirmed code.
// Assumes: cat is only meaningful while count_vld is high.
module refrate_decide
    import refrate_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cat_e  cat,
    input  logic  count_vld,
    output rate_e rate_code,
    output logic  rate_valid,
    output logic  ref_missing
);

    cat_e prev_cat;
    logic is_rate;
    logic agree;

    assign is_rate = (cat == CAT_LOW) || (cat == CAT_MID) || (cat == CAT_HIGH);
    assign agree   = is_rate && (cat == prev_cat);

    // Update history and outputs once per completed window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cat    <= CAT_OUT;
            rate_code   <= RATE_LOW;
            rate_valid  <= 1'b0;
            ref_missing <= 1'b0;
        end else if (count_vld) begin
            prev_cat    <= cat;
            rate_valid  <= agree;
            ref_missing <= (cat == CAT_ABSENT) && (prev_cat == CAT_ABSENT);
            if (agree) rate_code <= rate_e'(cat[1:0]);
        end
    end

endmodule

// File: rtl/refrate_detect.sv
// Reference clock rate detector, top level.
// Measures ref_clk against clk over fixed windows, classifies it as one of
// three nominal rates, flags its absence and gives the oscillator ratio.
// Assumes: clk is free-running; ref_clk may stop at any time.
module refrate_detect
    import refrate_pkg::*;
#(
    parameter int WIN_CYCLES = 2048,
    parameter int PRE_W      = 2,
    parameter int CNT_W      = 12,
    parameter int NOM_LOW    = 100,
    parameter int NOM_MID    = 398,
    parameter int NOM_HIGH   = 796,
    parameter int TOL_SHIFT  = 4,
    parameter int RATIO_W    = 8,
    parameter int RATIO_LOW  = 128,
    parameter int RATIO_MID  = 32,
    parameter int RATIO_HIGH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_clk,
    output logic [1:0]         rate_code,
    output logic               rate_valid,
    output logic               ref_missing,
    output logic [RATIO_W-1:0] vco_ratio
);

    localparam logic [CNT_W-1:0] LO_MIN_CNT = CNT_W'(NOM_LOW - (NOM_LOW >> TOL_SHIFT));

    logic [CNT_W-1:0] ref_gray;
    logic [CNT_W-1:0] ref_bin;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_vld;
    cat_e             win_cat;
    rate_e            code_e;

    refrate_ref_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_refcnt (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_q  (ref_gray)
    );

    refrate_sync #(.CNT_W(CNT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .gray_in (ref_gray),
        .bin_out (ref_bin)
    );

    refrate_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bin_now   (ref_bin),
        .count_q   (cnt_q),
        .count_vld (cnt_vld)
    );

    refrate_classify #(
        .CNT_W(CNT_W), .NOM_LOW(NOM_LOW), .NOM_MID(NOM_MID),
        .NOM_HIGH(NOM_HIGH), .TOL_SHIFT(TOL_SHIFT)
    ) u_cls (
        .count (cnt_q),
        .cat   (win_cat)
    );

    refrate_decide u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cat         (win_cat),
        .count_vld   (cnt_vld),
        .rate_code   (code_e),
        .rate_valid  (rate_valid),
        .ref_missing (ref_missing)
    );

    assign rate_code = code_e;

    // Oscillator multiplier for the current rate code
    always_comb begin
        case (code_e)
            RATE_MID:  vco_ratio = RATIO_W'(RATIO_MID);
            RATE_HIGH: vco_ratio = RATIO_W'(RATIO_HIGH);
            default:   vco_ratio = RATIO_W'(RATIO_LOW);
        endcase
    end

endmodule

// File: rtl/refrate_chk.sv
// Assertion checker for refrate_detect, attached by bind below.
module refrate_chk #(
    parameter int               CNT_W  = 12,
    parameter logic [CNT_W-1:0] LO_MIN = 94
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       rate_code,
    input logic             rate_valid,
    input logic             ref_missing,
    input logic             cnt_vld,
    input logic [CNT_W-1:0] cnt_q
);

    // R9
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_code != 2'd3);

    // R9
    valid_vs_missing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> !ref_missing);

    // R8
    hold_between_windows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_vld |=> ($stable(rate_code) && $stable(rate_valid) && $stable(ref_missing)));

    // R3
    code_change_confirmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_code) |-> rate_valid);

    // R5
    missing_needs_low_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_missing) |-> ($past(cnt_vld) && ($past(cnt_q) < LO_MIN)));

endmodule

bind refrate_detect refrate_chk #(.CNT_W(CNT_W), .LO_MIN(LO_MIN_CNT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_code   (rate_code),
    .rate_valid  (rate_valid),
    .ref_missing (ref_missing),
    .cnt_vld     (cnt_vld),
    .cnt_q       (cnt_q)
);

// File: tb/sim_refrate_detect.sv
// Bench for refrate_detect: 100 MHz local clock (time unit 1 ps),
// behavioural window model compared every cycle, plus named checks.
module sim_refrate_detect;

    localparam int WIN    = 2048;
    localparam int NWIN   = 17;
    localparam int HALF_T = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic [1:0] rate_code;
    logic       rate_valid;
    logic       ref_missing;
    logic [7:0] vco_ratio;

    int ref_half = 6430;   // reference half period in ps, 0 = stopped
    int ecount = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_code = 0, m_valid = 0, m_miss = 0, m_prev = 4;
    int catq[$];

    refrate_detect u0 (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .rate_code(rate_code), .rate_valid(rate_valid),
        .ref_missing(ref_missing), .vco_ratio(vco_ratio)
    );

    always #(HALF_T) clk = ~clk;

    // Reference generator with a run-time period
    always begin
        if (ref_half > 0) begin
            #(ref_half) ref_clk = ~ref_clk;
        end else begin
            ref_clk = 1'b0;
            #(1000);
        end
    end

    // Category per R2/R5/R4: 0..2 rate, 3 absent, 4 unrecognised
    function automatic int cat_of(int half);
        real n;
        if (half == 0) return 3;
        n = (WIN * 10000.0) / (2.0 * half) / 4.0;
        if (n < 94.0) return 3;
        if (n <= 106.0) return 0;
        if (n >= 374.0 && n <= 422.0) return 1;
        if (n >= 747.0 && n <= 845.0) return 2;
        return 4;
    endfunction

    // R7 table
    function automatic int ratio_of(int code);
        if (code == 1) return 32;
        if (code == 2) return 16;
        return 128;
    endfunction

    task automatic check_val(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at edge %0d", tag, got, exp, ecount);
        end
    endtask

    // Model: queue window categories, apply them on the decision edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ecount = 0;
            m_code = 0; m_valid = 0; m_miss = 0; m_prev = 4;
            catq.delete();
        end else begin
            ecount++;
            if (ecount > 2 * WIN && ((ecount - 1) % WIN) == 0 && catq.size() > 0) begin
                int c;
                c = catq.pop_front();
                m_valid = (c < 3 && c == m_prev) ? 1 : 0;
                if (m_valid == 1) m_code = c;
                m_miss = (c == 3 && m_prev == 3) ? 1 : 0;
                m_prev = c;
            end
            if ((ecount % WIN) == 0) catq.push_back(cat_of(ref_half));
        end
    end

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_val("R2 model rate_code", int'(rate_code), m_code);
            check_val("R3 model rate_valid", int'(rate_valid), m_valid);
            check_val("R5 model ref_missing", int'(ref_missing), m_miss);
            check_val("R7 model vco_ratio", int'(vco_ratio), ratio_of(m_code));
        end
    end

    // Window settings: half periods in ps
    int set_half [1:NWIN];
    int e_code   [1:NWIN];
    int e_valid  [1:NWIN];
    int e_miss   [1:NWIN];
    string e_tag [1:NWIN];

    task automatic plan(int j, int h, int c, int v, int m, string t);
        set_half[j] = h; e_code[j] = c; e_valid[j] = v; e_miss[j] = m; e_tag[j] = t;
    endtask

    initial begin
        // low 19.44, mid 77.76, high 155.52, bad 40, slow 5 MHz, mid +3 %
        plan(1,  6430,  0, 0, 0, "R3 first window unconfirmed");
        plan(2,  6430,  1, 1, 0, "R2 mid confirmed");
        plan(3,  3215,  1, 0, 0, "R3 new range drops valid keeps code");
        plan(4,  3215,  2, 1, 0, "R2 high confirmed");
        plan(5,  12500, 2, 0, 0, "R4 unrecognised keeps code");
        plan(6,  12500, 2, 0, 0, "R4 unrecognised twice");
        plan(7,  25720, 2, 0, 0, "R3 low single window");
        plan(8,  25720, 0, 1, 0, "R2 low confirmed");
        plan(9,  0,     0, 0, 0, "R5 single absent window");
        plan(10, 0,     0, 0, 1, "R5 absent twice");
        plan(11, 6243,  0, 0, 0, "R6 missing clears");
        plan(12, 6243,  1, 1, 0, "R10 mid plus 3 pct");
        plan(13, 100000, 1, 0, 0, "R5 slow single window");
        plan(14, 100000, 1, 0, 1, "R5 slow below lowest");
        plan(15, 3215,  1, 0, 0, "R6 high clears missing");
        plan(16, 25720, 1, 0, 0, "R3 disagreeing windows");
        plan(17, 25720, 0, 1, 0, "R3 low confirmed");
    end

    // Stimulus: change the reference half a cycle before each window edge
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int j = 1; j <= NWIN; j++) begin
            while (ecount != j * WIN - 1) @(negedge clk);
            ref_half = set_half[j];
        end
    end

    // Named checks
    initial begin
        @(negedge clk);
        check_val("R1 reset rate_code", int'(rate_code), 0);
        check_val("R1 reset rate_valid", int'(rate_valid), 0);
        check_val("R1 reset ref_missing", int'(ref_missing), 0);
        check_val("R1 reset vco_ratio", int'(vco_ratio), 128);
        wait (rst_n);
        @(negedge clk);
        check_val("R1 after release rate_valid", int'(rate_valid), 0);
        while (ecount != 2 * WIN) @(negedge clk);
        check_val("R8 no decision before second window ends", int'(rate_valid), 0);
        check_val("R8 code held before second window ends", int'(rate_code), 0);
        for (int j = 1; j <= NWIN; j++) begin
            while (ecount != (j + 1) * WIN + 1) @(negedge clk);
            check_val({e_tag[j], " rate_code"}, int'(rate_code), e_code[j]);
            check_val({e_tag[j], " rate_valid"}, int'(rate_valid), e_valid[j]);
            check_val({e_tag[j], " ref_missing"}, int'(ref_missing), e_miss[j]);
            check_val({e_tag[j], " R7 vco_ratio"}, int'(vco_ratio), ratio_of(e_code[j]));
        end
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got %0d expected %0d", ecount, (NWIN + 1) * WIN + 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule